// File: doc/BRIEF.md
# Preloadable Pace Interval Timer

This block sets the spacing between successive acquisition cycles. A host writes a 16-bit start value into a pace register. While an active-low load/count control is low, the timer copies that value and holds it. Once the control returns high, the timer counts upward by one on every clock-enable tick. It is built from cascaded 4-bit sections.

An active-low end flag stays high while the count is below all-ones and drops when the count reaches all-ones. It does not wait for the wrap to zero. The conversion sequencer raises a pace request when it wants to move on. While that request is high, the end flag is high and internal pacing is enabled, the block asserts a hold that stalls the sequencer. The hold lifts as soon as the end flag goes low.

Driving the pace-disable input high turns internal pacing off, so an external source can pace the cycles. With 600 ns ticks, software programs `0xFFF6 - round((P - 18 us) / 0.6 us)` for a period P. Start values from 0xFFF7 to 0xFFFF are legal and give little or no stall.

Top module: `pace_timer`

## Requirements
- R1: While `rstN` is low, the pace register and the count are zero, and `endN` is high.
- R2: A cycle with `hostWrEn` high stores `hostWrData` in the pace register at that clock edge. The stored value is kept until the next write.
- R3: At every clock edge where `loadN` is low, the count takes the value the pace register held before that edge. `tick` is ignored during those edges.
- R4: At an edge with `loadN` high, the count rises by one if `tick` is high and is unchanged if `tick` is low.
- R5: A carry out of a full 4-bit section advances the next section, so 0x0FFF steps to 0x1000 and 0xFFFF wraps to 0x0000.
- R6: `endN` is low exactly while the count is 0xFFFF. It returns high after the wrap to 0x0000.
- R7: `seqHold` is high exactly when `paceReq` is high, `endN` is high and `extPaceDis` is low.
- R8: While `extPaceDis` is high, `seqHold` stays low whatever the count and `paceReq` are.
- R9: A start value of 0xFFFF drives `endN` low directly after the load. A start value of 0xFFF7 drives it low after exactly 8 counting ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe for the pace register |
| hostWrData | input | 16 | Pace start value from the host |
| loadN | input | 1 | Active-low load/count control |
| tick | input | 1 | Count enable, one per timebase period |
| paceReq | input | 1 | Sequencer asks to wait for the pace interval |
| extPaceDis | input | 1 | High disables internal pacing |
| countVal | output | 16 | Current timer count |
| endN | output | 1 | Active-low end of interval, low at all-ones |
| seqHold | output | 1 | Stall for the conversion sequencer |

## Verification
The hardest case to reach is the moment the count sits at all-ones while a pace request is pending. Reaching it needs a preload near the top, a release of the load control, and exactly the right number of ticks, so random loads with a full 16-bit range almost never land there. Directed sequences therefore load 0xFFF0, 0xFFF7 and 0xFFFF, and 0x0FFF for the section carry, then tick up to the flag edge and back through the wrap. Random traffic biased toward high start values covers the rest of the input mixes.

// File: rtl/pace_pkg.sv
package pace_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } paceStrobes_t;
endpackage

// File: rtl/pace_ctrl.sv
module pace_ctrl
  import pace_pkg::*;
(
  input  logic         loadN,
  input  logic         tick,
  input  logic         paceReq,
  input  logic         extPaceDis,
  input  logic         endN,
  output paceStrobes_t strobes,
  output logic         seqHold
);
  logic paceEn;

  always_comb begin
    strobes.load    = ~loadN;
    strobes.advance = loadN & tick;
    paceEn          = ~extPaceDis;
    seqHold         = paceReq & endN & paceEn;
  end
endmodule

// File: rtl/pace_datapath.sv
module pace_datapath
  import pace_pkg::*;
#(
  parameter int SECTION_W    = 4,
  parameter int NUM_SECTIONS = 4,
  localparam int COUNT_W     = SECTION_W * NUM_SECTIONS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [COUNT_W-1:0] hostWrData,
  input  paceStrobes_t       strobes,
  output logic [COUNT_W-1:0] paceRegQ,
  output logic [COUNT_W-1:0] countVal,
  output logic               endN
);
  logic [NUM_SECTIONS:0]   carryChain;
  logic [NUM_SECTIONS-1:0] sectFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         paceRegQ <= '0;
    else if (hostWrEn) paceRegQ <= hostWrData;
  end

  assign carryChain[0] = strobes.advance;

  for (genvar s = 0; s < NUM_SECTIONS; s++) begin : g_sect
    logic [SECTION_W-1:0] sectQ;
    assign sectFull[s]     = &sectQ;
    assign carryChain[s+1] = carryChain[s] & sectFull[s];
    assign countVal[s*SECTION_W +: SECTION_W] = sectQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              sectQ <= '0;
      else if (strobes.load)  sectQ <= paceRegQ[s*SECTION_W +: SECTION_W];
      else if (carryChain[s]) sectQ <= sectQ + 1'b1;
    end
  end

  assign endN = ~(&sectFull);
endmodule

// File: rtl/pace_timer.sv
module pace_timer
  import pace_pkg::*;
#(
  parameter int SECTION_W    = 4,
  parameter int NUM_SECTIONS = 4,
  localparam int COUNT_W     = SECTION_W * NUM_SECTIONS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [COUNT_W-1:0] hostWrData,
  input  logic               loadN,
  input  logic               tick,
  input  logic               paceReq,
  input  logic               extPaceDis,
  output logic [COUNT_W-1:0] countVal,
  output logic               endN,
  output logic               seqHold
);
  paceStrobes_t       strobes;
  logic [COUNT_W-1:0] paceRegQ;

  pace_ctrl u_ctrl (
    .loadN(loadN), .tick(tick), .paceReq(paceReq), .extPaceDis(extPaceDis),
    .endN(endN), .strobes(strobes), .seqHold(seqHold)
  );

  pace_datapath #(.SECTION_W(SECTION_W), .NUM_SECTIONS(NUM_SECTIONS)) u_dp (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .strobes(strobes), .paceRegQ(paceRegQ), .countVal(countVal), .endN(endN)
  );
endmodule

// File: rtl/pace_timer_chk.sv
module pace_timer_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadN,
  input logic               tick,
  input logic               paceReq,
  input logic               extPaceDis,
  input logic [COUNT_W-1:0] paceRegQ,
  input logic [COUNT_W-1:0] countVal,
  input logic               endN,
  input logic               seqHold
);
  localparam logic [COUNT_W-1:0] ALL_ONES = '1;
  localparam logic [COUNT_W-1:0] NEAR_TOP = ALL_ONES - 1'b1;

  a_r1_reset_clear: assert property (@(posedge clk) !rstN |-> (countVal == '0 && endN));

  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> (countVal == $past(paceRegQ)));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && tick) |=> (countVal == $past(countVal) + 1'b1));

  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !tick) |=> $stable(countVal));

  a_r6_end_falls: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && tick && countVal == NEAR_TOP) |=> !endN);

  a_r6_end_rises: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && tick && !endN) |=> endN);

  a_r7_no_hold_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !endN |-> !seqHold);

  a_r8_ext_no_hold: assert property (@(posedge clk) disable iff (!rstN)
    extPaceDis |-> !seqHold);
endmodule

bind pace_timer pace_timer_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadN(loadN), .tick(tick), .paceReq(paceReq),
  .extPaceDis(extPaceDis), .paceRegQ(paceRegQ), .countVal(countVal),
  .endN(endN), .seqHold(seqHold)
);

// File: tb/pace_timer_tb.sv
module pace_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic loadN = 1'b0, tick = 1'b0, paceReq = 1'b0, extPaceDis = 1'b0;
  logic [15:0] countVal;
  logic endN, seqHold;

  int checks = 0, failures = 0;
  logic [15:0] expReg = '0, expCnt = '0;

  always #2.5 clk = ~clk;

  pace_timer u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .loadN(loadN), .tick(tick), .paceReq(paceReq), .extPaceDis(extPaceDis),
    .countVal(countVal), .endN(endN), .seqHold(seqHold)
  );

  function automatic logic expEnd(input logic [15:0] c);
    return (c != 16'hFFFF);
  endfunction

  function automatic logic expHold(input logic [15:0] c, input logic rq, input logic ds);
    return rq & expEnd(c) & ~ds;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic tk, input logic wr, input logic [15:0] d,
                      input logic rq, input logic ds);
    @(negedge clk);
    loadN = ld; tick = tk; hostWrEn = wr; hostWrData = d; paceReq = rq; extPaceDis = ds;
    @(posedge clk);
    if (!ld) expCnt = expReg;
    else if (tk) expCnt = expCnt + 16'd1;
    if (wr) expReg = d;
    #1;
    check(countVal == expCnt, ld ? "R4/R5 count" : "R3 load", countVal, expCnt);
    check(endN == expEnd(expCnt), "R6 endN", {15'd0, endN}, {15'd0, expEnd(expCnt)});
    check(seqHold == expHold(expCnt, rq, ds), ds ? "R8 ext disable" : "R7 hold",
          {15'd0, seqHold}, {15'd0, expHold(expCnt, rq, ds)});
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(countVal == 16'h0, "R1 count in reset", countVal, 16'h0);
    check(endN == 1'b1, "R1 endN in reset", {15'd0, endN}, 16'h1);
    @(negedge clk); rstN = 1'b1;

    // R2: write then retain across idle cycles, observed through a later load
    step(1, 0, 1, 16'h1234, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 0, 16'hDEAD, 0, 0);
    step(0, 1, 0, 16'h0, 0, 0);
    check(countVal == 16'h1234, "R2 retained value", countVal, 16'h1234);

    // R3: tick ignored while loading
    for (int i = 0; i < 3; i++) step(0, 1, 0, 16'h0, 1, 0);

    // R5: section carry
    step(1, 0, 1, 16'h0FFF, 0, 0);
    step(0, 0, 0, 16'h0, 0, 0);
    step(1, 1, 0, 16'h0, 0, 0);
    check(countVal == 16'h1000, "R5 section carry", countVal, 16'h1000);

    // R6/R7: reach all-ones with a pending request, then wrap
    step(1, 0, 1, 16'hFFF0, 1, 0);
    step(0, 0, 0, 16'h0, 1, 0);
    for (int i = 0; i < 14; i++) step(1, 1, 0, 16'h0, 1, 0);
    check(seqHold == 1'b1, "R7 hold before end", {15'd0, seqHold}, 16'h1);
    step(1, 1, 0, 16'h0, 1, 0);
    check(endN == 1'b0, "R6 end at FFFF", {15'd0, endN}, 16'h0);
    check(seqHold == 1'b0, "R7 released at end", {15'd0, seqHold}, 16'h0);
    step(1, 0, 0, 16'h0, 1, 0);
    step(1, 1, 0, 16'h0, 1, 0);
    check(countVal == 16'h0 && endN, "R5/R6 wrap", countVal, 16'h0);

    // R8: external pacing
    step(1, 1, 0, 16'h0, 1, 1);
    check(seqHold == 1'b0, "R8 no hold", {15'd0, seqHold}, 16'h0);

    // R9: high start values
    step(1, 0, 1, 16'hFFFF, 1, 0);
    step(0, 0, 0, 16'h0, 1, 0);
    check(endN == 1'b0, "R9 FFFF immediate end", {15'd0, endN}, 16'h0);
    step(1, 0, 1, 16'hFFF7, 1, 0);
    step(0, 0, 0, 16'h0, 1, 0);
    for (int i = 0; i < 7; i++) step(1, 1, 0, 16'h0, 1, 0);
    check(endN == 1'b1, "R9 FFF7 not yet", {15'd0, endN}, 16'h1);
    step(1, 1, 0, 16'h0, 1, 0);
    check(endN == 1'b0, "R9 FFF7 after 8 ticks", {15'd0, endN}, 16'h0);

    // Random traffic, start values biased toward the top
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      d = ($urandom % 2) ? (16'hFFE0 | 16'($urandom % 32)) : 16'($urandom);
      step(($urandom % 16) != 0, ($urandom % 4) != 0, ($urandom % 8) == 0, d,
           ($urandom % 2) == 1, ($urandom % 8) == 0);
    end

    finishRun();
  end
endmodule